// File: doc/BRIEF.md
# Optimized State-Save Mask Controller

This block decides what one optimized save of processor state does. A save is started with a one-cycle pulse. The block first checks whether the save may run at all, and reports one fault code if it may not. If the save may run, it computes two words. The first is the new header word that records which state components hold live data. The second is a bitmask of the components whose contents must be written to memory. It does not compute memory offsets and it does not move any data.

Two optimizations make the write mask smaller. The first drops components that are not in use, meaning they are still in their initial configuration. The second also drops components that have not been modified since the last restore. The second optimization is allowed only when a restore record matches the current context. The record holds four fields: the privilege level at the restore, the guest-mode flag at the restore, the save address of the restore, and a form tag that must be zero. In-use bit 1 covers only the vector registers and not the vector control/status word. Header bit 1 can therefore be 0 even when that control word differs from its reset value.

Top module: `ssm_ctrl`

## Requirements
- R1: Faults are ranked in this order. If `ext_en` is 0 the fault code is 1 (bad operation). Otherwise, if `dev_lock` is 1 the code is 2 (device unavailable). Otherwise, if `save_addr[5:0]` is nonzero the code is 3 (protection). If none of these apply the code is 0.
- R2: On a misaligned address with `ext_en`=1 and `dev_lock`=0, the code is 4 (alignment) instead of 3 when all of the following hold: `align_chk_en`=1, `ac_flag`=1 and `priv_lvl`=3.
- R3: A save that faults produces an all-zero `save_mask`, keeps `hdr_wr_en` low and returns `hdr_out` equal to `hdr_in`. A save that does not fault pulses `hdr_wr_en` together with `done`.
- R4: On a save without a fault, each bit of `hdr_out` follows one rule. Where the matching `req_mask` bit is 1, the bit equals the matching `inuse` bit. Where the `req_mask` bit is 0, the bit equals the matching `hdr_in` bit.
- R5: When the modified optimization does not apply, `save_mask` equals `req_mask & inuse`, and `modified` has no effect.
- R6: After a standard, non-compacted restore, a save applies the modified optimization when three things match the recorded values: the privilege level, the guest flag and the address. In that case `save_mask` equals `req_mask & inuse & modified`.
- R7: A difference in any one of the recorded privilege, guest flag or address disables the modified optimization.
- R8: The modified optimization is disabled after either of two events: a restore flagged `rest_compact`, or a supervisor restore that follows the last standard restore. It stays disabled until the next standard, non-compacted restore.
- R9: After reset, `done`, `hdr_wr_en`, `save_mask` and `fault_code` are 0. The restore record is invalid, so the first save never applies the modified optimization.
- R10: All results are registered on the clock edge that samples `start`. `done` is high for exactly that one following cycle. The outputs other than `done` and `hdr_wr_en` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle save request |
| req_mask | input | NCOMP | Requested components |
| inuse | input | NCOMP | Per-component in-use flags |
| modified | input | NCOMP | Per-component modified-since-restore flags |
| ext_en | input | 1 | Extended state saving enabled by the OS |
| dev_lock | input | 1 | Task-switched lock on the state unit |
| align_chk_en | input | 1 | Alignment checking enabled |
| ac_flag | input | 1 | Alignment-check flag of the running code |
| priv_lvl | input | 2 | Current privilege level |
| guest_mode | input | 1 | Running as a virtualized guest |
| save_addr | input | ADDR_W | Linear address of the save area |
| hdr_in | input | NCOMP | Header word currently stored in memory |
| rest_evt | input | 1 | Standard restore completed |
| rest_compact | input | 1 | That restore used the compacted form |
| sup_rest_evt | input | 1 | Supervisor restore completed |
| done | output | 1 | Results valid strobe |
| fault_code | output | 3 | 0 none, 1 bad operation, 2 device unavailable, 3 protection, 4 alignment |
| hdr_wr_en | output | 1 | Header word must be written back |
| hdr_out | output | NCOMP | New header word |
| save_mask | output | NCOMP | Components to write to memory |

## Verification
The mask logic is tried with three kinds of request word: all ones, all zeros, and an alternating pattern. Each is paired with `inuse`, `modified` and `hdr_in` words that differ from one another. This shows which word each output bit is taken from. Each save runs once with a matching restore record and then again with a single field changed: privilege, guest flag, address, compacted form, or a later supervisor restore. The `modified` word is then the only word whose presence changes the mask. Fault saves stack several fault conditions at once to confirm the ranking. They also flip each condition of the alignment case one at a time.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_BADOP = 3'd1,
    FLT_NODEV = 3'd2,
    FLT_PROT  = 3'd3,
    FLT_ALIGN = 3'd4
  } fault_e;

  localparam int unsigned PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_USER = 2'd3;
endpackage

// File: rtl/ssm_fault_chk.sv
module ssm_fault_chk
  import ssm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned ALIGN_LG = 6
) (
  input  logic              ext_en,
  input  logic              dev_lock,
  input  logic              align_chk_en,
  input  logic              ac_flag,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic [ADDR_W-1:0] save_addr,
  output fault_e            fault
);
  logic misaligned;
  logic ac_route;

  assign misaligned = |save_addr[ALIGN_LG-1:0];
  assign ac_route   = align_chk_en && ac_flag && (priv_lvl == PRIV_USER);

  always_comb begin
    if (!ext_en)         fault = FLT_BADOP;
    else if (dev_lock)   fault = FLT_NODEV;
    else if (misaligned) fault = ac_route ? FLT_ALIGN : FLT_PROT;
    else                 fault = FLT_NONE;
  end
endmodule

// File: rtl/ssm_restore_rec.sv
module ssm_restore_rec
  import ssm_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned TAG_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rest_evt,
  input  logic              rest_compact,
  input  logic              sup_rest_evt,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              guest_mode,
  input  logic [ADDR_W-1:0] save_addr,
  output logic              rec_match
);
  localparam logic [TAG_W-1:0] TAG_CMPCT = TAG_W'(1);
  localparam logic [TAG_W-1:0] TAG_SUPER = TAG_W'(2);

  typedef struct packed {
    logic [PRIV_W-1:0] priv;
    logic              guest;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } rec_t;

  rec_t rec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q.priv  <= '0;
      rec_q.guest <= 1'b0;
      rec_q.addr  <= '0;
      rec_q.tag   <= TAG_CMPCT | TAG_SUPER;
    end else begin
      if (rest_evt) begin
        rec_q.priv  <= priv_lvl;
        rec_q.guest <= guest_mode;
        rec_q.addr  <= save_addr;
        rec_q.tag   <= rest_compact ? TAG_CMPCT : '0;
      end
      if (sup_rest_evt) begin
        rec_q.tag <= TAG_SUPER;
      end
    end
  end

  assign rec_match = (rec_q.tag == '0) &&
                     (rec_q.priv == priv_lvl) &&
                     (rec_q.guest == guest_mode) &&
                     (rec_q.addr == save_addr);
endmodule

// File: rtl/ssm_mask_calc.sv
module ssm_mask_calc #(
  parameter int unsigned NCOMP = 64
) (
  input  logic [NCOMP-1:0] req_mask,
  input  logic [NCOMP-1:0] inuse,
  input  logic [NCOMP-1:0] modified,
  input  logic [NCOMP-1:0] hdr_in,
  input  logic             use_mod,
  output logic [NCOMP-1:0] mask,
  output logic [NCOMP-1:0] hdr_new
);
  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    logic live;
    assign live       = req_mask[i] && inuse[i];
    assign mask[i]    = live && (!use_mod || modified[i]);
    assign hdr_new[i] = req_mask[i] ? inuse[i] : hdr_in[i];
  end
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int unsigned NCOMP    = 64,
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned ALIGN_LG = 6,
  parameter int unsigned TAG_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NCOMP-1:0]  req_mask,
  input  logic [NCOMP-1:0]  inuse,
  input  logic [NCOMP-1:0]  modified,
  input  logic              ext_en,
  input  logic              dev_lock,
  input  logic              align_chk_en,
  input  logic              ac_flag,
  input  logic [1:0]        priv_lvl,
  input  logic              guest_mode,
  input  logic [ADDR_W-1:0] save_addr,
  input  logic [NCOMP-1:0]  hdr_in,
  input  logic              rest_evt,
  input  logic              rest_compact,
  input  logic              sup_rest_evt,
  output logic              done,
  output logic [2:0]        fault_code,
  output logic              hdr_wr_en,
  output logic [NCOMP-1:0]  hdr_out,
  output logic [NCOMP-1:0]  save_mask
);
  fault_e           fault_c;
  logic             rec_match;
  logic [NCOMP-1:0] mask_c;
  logic [NCOMP-1:0] hdr_c;

  ssm_fault_chk #(.ADDR_W(ADDR_W), .ALIGN_LG(ALIGN_LG)) u_fault (
    .ext_en       (ext_en),
    .dev_lock     (dev_lock),
    .align_chk_en (align_chk_en),
    .ac_flag      (ac_flag),
    .priv_lvl     (priv_lvl),
    .save_addr    (save_addr),
    .fault        (fault_c)
  );

  ssm_restore_rec #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_rec (
    .clk          (clk),
    .rst          (rst),
    .rest_evt     (rest_evt),
    .rest_compact (rest_compact),
    .sup_rest_evt (sup_rest_evt),
    .priv_lvl     (priv_lvl),
    .guest_mode   (guest_mode),
    .save_addr    (save_addr),
    .rec_match    (rec_match)
  );

  ssm_mask_calc #(.NCOMP(NCOMP)) u_mask (
    .req_mask (req_mask),
    .inuse    (inuse),
    .modified (modified),
    .hdr_in   (hdr_in),
    .use_mod  (rec_match),
    .mask     (mask_c),
    .hdr_new  (hdr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      fault_code <= FLT_NONE;
      hdr_wr_en  <= 1'b0;
      hdr_out    <= '0;
      save_mask  <= '0;
    end else begin
      done      <= start;
      hdr_wr_en <= 1'b0;
      if (start) begin
        fault_code <= fault_c;
        if (fault_c != FLT_NONE) begin
          save_mask <= '0;
          hdr_out   <= hdr_in;
        end else begin
          save_mask <= mask_c;
          hdr_out   <= hdr_c;
          hdr_wr_en <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssm_ctrl_chk.sv
module ssm_ctrl_chk #(
  parameter int unsigned NCOMP  = 64,
  parameter int unsigned ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [NCOMP-1:0]  req_mask,
  input logic [NCOMP-1:0]  inuse,
  input logic              ext_en,
  input logic [NCOMP-1:0]  hdr_in,
  input logic              done,
  input logic [2:0]        fault_code,
  input logic              hdr_wr_en,
  input logic [NCOMP-1:0]  hdr_out,
  input logic [NCOMP-1:0]  save_mask
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst) done |-> $past(start)); // R10
  AST_WREN_WITH_DONE: assert property (@(posedge clk) disable iff (rst) hdr_wr_en |-> done); // R3
  AST_FAULT_NO_MASK: assert property (@(posedge clk) disable iff (rst) (done && fault_code != 3'd0) |-> (save_mask == '0 && !hdr_wr_en)); // R3
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst) (done && fault_code == 3'd0) |-> ((save_mask & ~($past(req_mask) & $past(inuse))) == '0)); // R5
  AST_HDR_UNREQ_KEPT: assert property (@(posedge clk) disable iff (rst) done |-> (((hdr_out ^ $past(hdr_in)) & ~$past(req_mask)) == '0)); // R4
  AST_BADOP_FIRST: assert property (@(posedge clk) disable iff (rst) (done && !$past(ext_en)) |-> (fault_code == 3'd1)); // R1
endmodule

bind ssm_ctrl ssm_ctrl_chk #(.NCOMP(NCOMP), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ssm_ctrl_bench.sv
module ssm_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 64;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NC-1:0] req_mask = '0, inuse = '0, modified = '0, hdr_in = '0;
  logic ext_en = 1'b1, dev_lock = 1'b0, align_chk_en = 1'b0, ac_flag = 1'b0;
  logic [1:0] priv_lvl = 2'd0;
  logic guest_mode = 1'b0;
  logic [AW-1:0] save_addr = '0;
  logic rest_evt = 1'b0, rest_compact = 1'b0, sup_rest_evt = 1'b0;
  logic done, hdr_wr_en;
  logic [2:0] fault_code;
  logic [NC-1:0] hdr_out, save_mask;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssm_ctrl u_ssm_ctrl (.*);

  localparam logic [NC-1:0] P_REQ = 64'hF0F0_1234_FFFF_000F;
  localparam logic [NC-1:0] P_USE = 64'hAAAA_5555_0FF0_00FF;
  localparam logic [NC-1:0] P_MOD = 64'h0F0F_3333_C3C3_0F0F;
  localparam logic [NC-1:0] P_HDR = 64'h9696_6969_A5A5_5A5A;
  localparam logic [AW-1:0] A0 = 48'h0000_1234_5600;

  task automatic chk(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_save(logic [NC-1:0] rq, logic [NC-1:0] us, logic [NC-1:0] md, logic [NC-1:0] hd);
    @(negedge clk);
    req_mask = rq; inuse = us; modified = md; hdr_in = hd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_restore(logic cmp, logic sup);
    @(negedge clk);
    rest_evt = ~sup; rest_compact = cmp; sup_rest_evt = sup;
    @(negedge clk);
    rest_evt = 1'b0; rest_compact = 1'b0; sup_rest_evt = 1'b0;
  endtask

  task automatic set_ctx(logic [1:0] p, logic g, logic [AW-1:0] a);
    @(negedge clk);
    priv_lvl = p; guest_mode = g; save_addr = a;
  endtask

  task automatic t_reset();
    chk("R9 done", NC'(done), '0);
    chk("R9 wr", NC'(hdr_wr_en), '0);
    chk("R9 mask", save_mask, '0);
    chk("R9 fault", NC'(fault_code), '0);
    set_ctx(2'd0, 1'b0, '0);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R9 first save no mod opt", save_mask, P_REQ & P_USE);
  endtask

  task automatic t_faults();
    set_ctx(2'd3, 1'b0, A0 | 48'h4);
    ext_en = 1'b0; dev_lock = 1'b1; align_chk_en = 1'b1; ac_flag = 1'b1;
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R1 badop first", NC'(fault_code), 64'd1);
    chk("R3 fault mask zero", save_mask, '0);
    chk("R3 fault hdr kept", hdr_out, P_HDR);
    chk("R3 fault no write", NC'(hdr_wr_en), '0);
    ext_en = 1'b1;
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R1 nodev second", NC'(fault_code), 64'd2);
    dev_lock = 1'b0;
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R2 alignment fault", NC'(fault_code), 64'd4);
    ac_flag = 1'b0;
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R2 ac off gives protection", NC'(fault_code), 64'd3);
    ac_flag = 1'b1; priv_lvl = 2'd2;
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R2 priv 2 gives protection", NC'(fault_code), 64'd3);
    align_chk_en = 1'b0; priv_lvl = 2'd3;
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R1 protection", NC'(fault_code), 64'd3);
    save_addr = A0;
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R1 aligned no fault", NC'(fault_code), 64'd0);
    ac_flag = 1'b0;
  endtask

  task automatic t_hdr();
    set_ctx(2'd0, 1'b0, A0);
    do_save('1, P_USE, P_MOD, P_HDR);
    chk("R4 all requested", hdr_out, P_USE);
    chk("R5 all requested", save_mask, P_USE);
    do_save('0, P_USE, P_MOD, P_HDR);
    chk("R4 none requested", hdr_out, P_HDR);
    chk("R5 none requested", save_mask, '0);
    do_save({32{2'b01}}, P_USE, P_MOD, P_HDR);
    chk("R4 alternating", hdr_out, ({32{2'b01}} & P_USE) | (~{32{2'b01}} & P_HDR));
    chk("R3 write pulse", NC'(hdr_wr_en), 64'd1);
    chk("R10 done pulse", NC'(done), 64'd1);
    @(negedge clk);
    chk("R10 done low after", NC'(done), '0);
    chk("R10 mask held", save_mask, {32{2'b01}} & P_USE);
  endtask

  task automatic t_modopt();
    set_ctx(2'd1, 1'b1, A0);
    do_restore(1'b0, 1'b0);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R6 match", save_mask, P_REQ & P_USE & P_MOD);
    set_ctx(2'd0, 1'b1, A0);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R7 priv differs", save_mask, P_REQ & P_USE);
    set_ctx(2'd1, 1'b0, A0);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R7 guest differs", save_mask, P_REQ & P_USE);
    set_ctx(2'd1, 1'b1, A0 + 48'h40);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R7 addr differs", save_mask, P_REQ & P_USE);
    set_ctx(2'd1, 1'b1, A0);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R6 match again", save_mask, P_REQ & P_USE & P_MOD);
  endtask

  task automatic t_invalidate();
    do_restore(1'b1, 1'b0);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R8 compact restore", save_mask, P_REQ & P_USE);
    do_restore(1'b0, 1'b0);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R8 standard restore revalidates", save_mask, P_REQ & P_USE & P_MOD);
    do_restore(1'b0, 1'b1);
    do_save(P_REQ, P_USE, P_MOD, P_HDR);
    chk("R8 supervisor restore", save_mask, P_REQ & P_USE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_faults();
    t_hdr();
    t_modopt();
    t_invalidate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule